// File: doc/BRIEF.md
# Zero-Crossing Pulse Generator

This block watches a stream of signed, band-limited audio samples and reports each time the signal changes polarity. It fires on positive-going and on negative-going transitions alike. For each one it drops an active-low output line for a fixed number of system clocks. The line is meant for a processor interrupt input, and software measures tone frequency from the pulse spacing. An optional counter gives the running number of crossings detected.

Polarity is tracked with a hysteresis band of plus or minus `HYST` around zero. Samples inside the band, zero included, leave the stored polarity unchanged, so noise near zero cannot produce repeated triggers. After reset the stored polarity is unknown. The first decisive sample only sets the polarity and does not fire.

The pulse shaper is a three-state machine. `ST_IDLE` holds the line high. On a crossing it takes the transition idle-to-pulse. `ST_PULSE` holds the line low while a counter runs. When `PULSE_CLKS` cycles have passed it takes pulse-to-idle. If a new crossing arrives first it takes pulse-to-gap instead. `ST_GAP` holds the line high for exactly one clock and then always takes gap-to-pulse, which starts a fresh full-width pulse. This way two close crossings still show up as two separate falling edges.

Top module: `zc_pulse_gen`

## Requirements
- R1: While reset is held and directly after it, `pulse_n_o` is 1 and `cross_count_o` is 0.
- R2: A positive-going crossing produces exactly one low pulse. A positive-going crossing is an accepted sample greater than `HYST`, taken when the stored polarity is negative.
- R3: A negative-going crossing produces exactly one low pulse. A negative-going crossing is an accepted sample less than `-HYST`, taken when the stored polarity is positive.
- R4: If the crossing sample is accepted at clock edge k, `pulse_n_o` is still high after edge k and goes low after edge k+1. It then stays low for exactly `PULSE_CLKS` clocks, unless R8 applies.
- R5: The first sample after reset that lies outside the band only sets the stored polarity and produces no pulse.
- R6: An accepted sample with a value from `-HYST` to `+HYST` inclusive, zero among them, leaves the stored polarity unchanged and produces no pulse.
- R7: When `sample_valid_i` is 0, `sample_i` is ignored. No pulse is produced, the counter does not move, and the stored polarity is kept.
- R8: If a crossing is detected while a pulse is low, the line returns high for exactly one clock and then a new pulse of full `PULSE_CLKS` width begins.
- R9: `cross_count_o` increments by one for every detected crossing and wraps modulo 2^`COUNT_W`.
- R10: An accepted sample beyond the band with the same polarity as the stored one produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_valid_i | input | 1 | Strobe that marks `sample_i` as a new sample |
| sample_i | input | SAMPLE_W | Signed two's-complement audio sample |
| pulse_n_o | output | 1 | Active-low crossing pulse, idles at 1 |
| cross_count_o | output | COUNT_W | Running crossing count, held at 0 when `COUNT_EN` is 0 |

## Verification
The shaper's assertions assume that two detected crossings are never accepted on consecutive clocks. A crossing arriving while the machine is in `ST_GAP` would merge with the pending pulse, so the gap-state check treats that as an input fault. The stimulus applies at most one valid sample per task step and leaves several clocks between the two crossings of the retrigger scenario, so it stays within this assumption. The polarity checks assume `HYST` is smaller than the largest positive sample value, and every sample the bench drives fits in `SAMPLE_W` bits.

// File: rtl/zc_pkg.sv
package zc_pkg;

    typedef enum logic [1:0] {
        SGN_UNKNOWN = 2'd0,
        SGN_POS     = 2'd1,
        SGN_NEG     = 2'd2
    } sgn_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } pst_e;

endpackage

// File: rtl/zc_sign_track.sv
module zc_sign_track
    import zc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int HYST     = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       valid_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic                       xing_o
);

    localparam logic signed [SAMPLE_W-1:0] HI_LIM = SAMPLE_W'(HYST);
    localparam logic signed [SAMPLE_W-1:0] LO_LIM = -HI_LIM;

    sgn_e sign_q;
    sgn_e sign_new;
    logic decisive;
    logic xing_q;

    // Classify the incoming sample against the hysteresis band.
    always_comb begin
        sign_new = sign_q;
        decisive = 1'b0;
        if (valid_i) begin
            if (sample_i > HI_LIM) begin
                sign_new = SGN_POS;
                decisive = 1'b1;
            end else if (sample_i < LO_LIM) begin
                sign_new = SGN_NEG;
                decisive = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sign_q <= SGN_UNKNOWN;
            xing_q <= 1'b0;
        end else begin
            xing_q <= decisive && (sign_q != SGN_UNKNOWN) && (sign_new != sign_q);
            if (decisive) begin
                sign_q <= sign_new;
            end
        end
    end

    assign xing_o = xing_q;

    // An unknown polarity can never yield a crossing.
    p_no_first_xing_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (sign_q == SGN_UNKNOWN) |=> !xing_q);

    // Samples inside the band, or not strobed, keep polarity and do not fire.
    p_band_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!valid_i || (sample_i <= HI_LIM && sample_i >= LO_LIM))
        |=> (!xing_q && sign_q == $past(sign_q)));

    p_ignore_strobe_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> $stable(sign_q));

    p_same_pos_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && sign_q == SGN_POS && sample_i > HI_LIM) |=> !xing_q);

    p_same_neg_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && sign_q == SGN_NEG && sample_i < LO_LIM) |=> !xing_q);

    p_pos_going_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && sign_q == SGN_NEG && sample_i > HI_LIM) |=> xing_q);

    p_neg_going_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && sign_q == SGN_POS && sample_i < LO_LIM) |=> xing_q);

endmodule

// File: rtl/zc_pulse_fsm.sv
module zc_pulse_fsm
    import zc_pkg::*;
#(
    parameter int PULSE_CLKS = 2000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic xing_i,
    output logic pulse_n_o
);

    localparam int CNT_W = $clog2(PULSE_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PULSE_CLKS - 1);

    pst_e             state_q;
    pst_e             state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next-state and count logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (xing_i) begin
                    state_d = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (xing_i) begin
                    state_d = ST_GAP;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_GAP: begin
                state_d = ST_PULSE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_PULSE: pulse_n_o = 1'b0;
            default:  pulse_n_o = 1'b1;
        endcase
    end

    p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_PULSE) |-> (cnt_q < CNT_W'(PULSE_CLKS)));

    p_full_width_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(pulse_n_o) && !$past(xing_i)) |-> ($past(cnt_q) == LAST_CNT));

    p_fall_cause_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pulse_n_o) |-> ($past(xing_i) || $past(state_q) == ST_GAP));

    p_retrig_high_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_PULSE && xing_i) |=> pulse_n_o);

    p_gap_one_clk_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_GAP) |=> !pulse_n_o);

    // Input expectation: crossings are never on consecutive clocks.
    p_gap_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_GAP) |-> !xing_i);

endmodule

// File: rtl/zc_cross_count.sv
module zc_cross_count #(
    parameter int COUNT_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               xing_i,
    output logic [COUNT_W-1:0] count_o
);

    logic [COUNT_W-1:0] count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else if (xing_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    p_count_step_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        xing_i |=> (count_q == COUNT_W'($past(count_q) + 1'b1)));

    p_count_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !xing_i |=> $stable(count_q));

endmodule

// File: rtl/zc_pulse_gen.sv
module zc_pulse_gen #(
    parameter int SAMPLE_W   = 12,
    parameter int HYST       = 8,
    parameter int PULSE_CLKS = 2000,
    parameter int COUNT_W    = 16,
    parameter bit COUNT_EN   = 1'b1
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       sample_valid_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic                       pulse_n_o,
    output logic [COUNT_W-1:0]         cross_count_o
);

    logic xing;

    zc_sign_track #(
        .SAMPLE_W (SAMPLE_W),
        .HYST     (HYST)
    ) u_sign (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .valid_i  (sample_valid_i),
        .sample_i (sample_i),
        .xing_o   (xing)
    );

    zc_pulse_fsm #(
        .PULSE_CLKS (PULSE_CLKS)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .xing_i    (xing),
        .pulse_n_o (pulse_n_o)
    );

    generate
        if (COUNT_EN) begin : g_count
            zc_cross_count #(
                .COUNT_W (COUNT_W)
            ) u_count (
                .clk_i   (clk_i),
                .rst_i   (rst_i),
                .xing_i  (xing),
                .count_o (cross_count_o)
            );
        end else begin : g_no_count
            assign cross_count_o = '0;
        end
    endgenerate

    p_reset_idle_r1: assert property (@(posedge clk_i)
        rst_i |=> (pulse_n_o && cross_count_o == '0));

endmodule

// File: tb/zc_pulse_gen_tb.sv
module zc_pulse_gen_tb_top;

    localparam int SW  = 12;
    localparam int HY  = 8;
    localparam int PW  = 20;
    localparam int CW  = 4;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 valid;
    logic signed [SW-1:0] sample;
    logic                 pulse_n;
    logic [CW-1:0]        count;

    int checks = 0;
    int fails  = 0;
    int exp_count = 0;

    // Port monitor, sampled on falling edges.
    logic prev_n = 1'b1;
    int   falls = 0, low_run = 0, high_run = 0, last_low = 0, last_gap = 0;

    always #5 clk = ~clk;

    zc_pulse_gen #(
        .SAMPLE_W   (SW),
        .HYST       (HY),
        .PULSE_CLKS (PW),
        .COUNT_W    (CW),
        .COUNT_EN   (1'b1)
    ) dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .sample_valid_i (valid),
        .sample_i       (sample),
        .pulse_n_o      (pulse_n),
        .cross_count_o  (count)
    );

    always @(negedge clk) begin
        if (!pulse_n) begin
            if (prev_n) begin
                falls++;
                last_gap = high_run;
                low_run = 0;
            end
            low_run++;
        end else begin
            if (!prev_n) begin
                last_low = low_run;
                high_run = 0;
            end
            high_run++;
        end
        prev_n = pulse_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input int v);
        @(negedge clk);
        valid  = 1'b1;
        sample = SW'(v);
        @(negedge clk);
        valid  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; valid = 1'b0; sample = '0;
        idle(3);
        check(pulse_n == 1'b1, "R1 pulse_n in reset", int'(pulse_n), 1);
        check(count == '0, "R1 count in reset", int'(count), 0);
        rst = 1'b0;
        idle(2);
        check(pulse_n == 1'b1, "R1 pulse_n after reset", int'(pulse_n), 1);
    endtask

    task automatic t_first();
        int f0 = falls;
        drive(100);
        idle(PW + 4);
        check(falls == f0, "R5 no pulse on first sample", falls - f0, 0);
        check(count == CW'(exp_count), "R5 count", int'(count), exp_count);
    endtask

    task automatic t_neg_cross();
        int f0 = falls;
        drive(-100);
        exp_count++;
        check(pulse_n == 1'b1, "R4 still high after accept edge", int'(pulse_n), 1);
        idle(1);
        check(pulse_n == 1'b0, "R4 low after next edge", int'(pulse_n), 0);
        idle(PW + 4);
        check(falls == f0 + 1, "R3 one pulse", falls - f0, 1);
        check(last_low == PW, "R4 pulse width", last_low, PW);
        check(count == CW'(exp_count), "R9 count after crossing", int'(count), exp_count);
    endtask

    task automatic t_pos_cross();
        int f0 = falls;
        drive(100);
        exp_count++;
        idle(PW + 5);
        check(falls == f0 + 1, "R2 one pulse", falls - f0, 1);
        check(last_low == PW, "R2 pulse width", last_low, PW);
    endtask

    task automatic t_hyst();
        int f0 = falls;
        drive(0); drive(-HY); drive(HY); drive(0); drive(-3);
        idle(PW + 4);
        check(falls == f0, "R6 in-band samples", falls - f0, 0);
        drive(-HY - 1);
        exp_count++;
        idle(PW + 4);
        check(falls == f0 + 1, "R6 just outside band fires", falls - f0, 1);
        check(count == CW'(exp_count), "R6 count", int'(count), exp_count);
    endtask

    task automatic t_same_sign();
        int f0 = falls;
        drive(-50); drive(-2000); drive(-HY - 1);
        idle(PW + 4);
        check(falls == f0, "R10 same polarity", falls - f0, 0);
        check(count == CW'(exp_count), "R10 count", int'(count), exp_count);
    endtask

    task automatic t_ignored();
        int f0 = falls;
        @(negedge clk);
        valid = 1'b0; sample = SW'(100);
        idle(10);
        check(falls == f0, "R7 no pulse without strobe", falls - f0, 0);
        check(count == CW'(exp_count), "R7 count held", int'(count), exp_count);
        drive(100);
        exp_count++;
        idle(PW + 4);
        check(falls == f0 + 1, "R7 polarity kept", falls - f0, 1);
    endtask

    task automatic t_retrig();
        int f0 = falls;
        drive(-100);
        idle(5);
        drive(100);
        exp_count += 2;
        idle(PW + 5);
        check(falls == f0 + 2, "R8 two distinct pulses", falls - f0, 2);
        check(last_gap == 1, "R8 one-clock gap", last_gap, 1);
        check(last_low == PW, "R8 second pulse full width", last_low, PW);
        check(count == CW'(exp_count), "R9 count after retrigger", int'(count), exp_count);
    endtask

    task automatic t_wrap();
        int f0 = falls;
        for (int i = 0; i < 12; i++) begin
            drive((i % 2 == 0) ? -300 : 300);
            exp_count++;
            idle(PW + 3);
        end
        check(falls == f0 + 12, "R9 pulses in train", falls - f0, 12);
        check(count == CW'(exp_count), "R9 count wraps", int'(count), exp_count % (1 << CW));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_first();
        t_neg_cross();
        t_pos_cross();
        t_hyst();
        t_same_sign();
        t_ignored();
        t_retrig();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule